// File: doc/BRIEF.md
# BCD Time-of-Day Register Bank

This block keeps the calendar time as packed BCD bytes (seconds, minutes, hours, weekday, date, month and a two-digit year) next to one control byte. Software reaches it through a byte-wide write port and a combinational read port that share one small address space. A one-second `tick` input advances the time. Every write is checked against the legal range and digit encoding of its field. A write that fails the check leaves the time as it was. A stop flag kept beside the seconds field freezes timekeeping until software clears it.

Carries run through a small ripple state machine that updates one field per clock. `ST_IDLE` accepts a tick when the stop flag is clear and increments seconds on that edge. If seconds wrap, the machine moves to `ST_MIN`. `ST_MIN` goes to `ST_HOUR` when minutes wrap and back to `ST_IDLE` otherwise. `ST_HOUR` goes to `ST_DAY` when hours wrap. `ST_DAY` advances the weekday and the date and goes to `ST_MONTH` when the date passes the length of the month. `ST_MONTH` goes to `ST_YEAR` when December wraps. `ST_YEAR` always returns to `ST_IDLE`.

Top module: `tod_bcd_regs`

## Requirements
- R1: After reset: control reads 0x90, seconds, minutes, hours and year read 0x00, weekday, date and month read 0x01, and the stop flag and the weekday flag are clear.
- R2: Slot 1 is seconds. A write stores bit 7 as the stop flag in every case. Bits 6:0 replace seconds only when both BCD digits are valid and the value is 00–59. A read returns the stop flag in bit 7 and the seconds in bits 6:0.
- R3: Slot 2 is minutes: bits 6:0 are taken, accepted 00–59. Slot 3 is hours: bits 5:0 are taken, accepted 00–23. Bits above the mask are ignored.
- R4: Slot 5 is the date: bits 5:0, accepted 01–31. Slot 6 is the month: bits 4:0, accepted 01–12. Slot 7 is the year: all 8 bits, accepted 00–99. A value with a digit above 9 is rejected.
- R5: Slot 4 is the weekday. Bit 6 of a write is always stored as a flag. Bits 2:0 replace the weekday only when they are 1–7. A read returns the flag in bit 6 and the weekday in bits 2:0, with all other bits zero.
- R6: Slot 0 is control. A write stores the byte with bit 5 cleared and bits 7 and 4 set.
- R7: A tick seen in `ST_IDLE` with the stop flag clear increments seconds on that edge. Each carry updates the next field one cycle later, in the order minutes, hours, date and weekday, month, year. A tick that arrives while a carry is still in progress is dropped.
- R8: While the stop flag is set, ticks have no effect. After the flag is cleared, counting resumes from the frozen value.
- R9: The date wraps to 01 and carries into the month when it has reached the month length: 30 for April, June, September and November, 31 for the other long months, and February 28, or 29 when the binary year is divisible by 4.
- R10: Each date carry also advances the weekday from 1 to 7, and 7 wraps back to 1.
- R11: Slots 8 to 2^ADDR_W−1 hold no storage. They read 0x00, and writes to them change nothing.
- R12: If a write reaches a field in the same cycle as a carry update to that field, the written value is kept, and the carry still continues to the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance strobe, one cycle wide |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write slot |
| wr_data | input | 8 | Write byte |
| rd_addr | input | ADDR_W | Read slot |
| rd_data | output | 8 | Read byte for `rd_addr`, combinational |

## Verification
The read port is combinational, and the bench sweeps every slot on every clock. A field that is wrong inside the block therefore shows up at `rd_data` in the cycle right after the edge that corrupted it. A ripple state that is stuck or skips a step shows up as a higher field that updates one cycle early, one cycle late, or not at all. This is seen within six cycles of the tick that started the carry. A wrong range check or a wrong mask leaves a field that differs from the reference on the first read after the write.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned NUM_FIELDS = 8;

    localparam int unsigned SLOT_CTRL  = 0;
    localparam int unsigned SLOT_SEC   = 1;
    localparam int unsigned SLOT_MIN   = 2;
    localparam int unsigned SLOT_HOUR  = 3;
    localparam int unsigned SLOT_WDAY  = 4;
    localparam int unsigned SLOT_DATE  = 5;
    localparam int unsigned SLOT_MON   = 6;
    localparam int unsigned SLOT_YEAR  = 7;

    typedef logic [BYTE_W-1:0] tod_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_MONTH,
        ST_YEAR
    } ripple_st_e;

    typedef struct packed {
        tod_byte_t ctrl;
        tod_byte_t sec;
        tod_byte_t min;
        tod_byte_t hour;
        tod_byte_t wday;
        tod_byte_t date;
        tod_byte_t mon;
        tod_byte_t year;
    } tod_regs_t;

    typedef struct packed {
        logic ctrl;
        logic sec;
        logic stop;
        logic min;
        logic hour;
        logic wday;
        logic wflag;
        logic date;
        logic mon;
        logic year;
    } tod_load_t;

    typedef struct packed {
        logic sec;
        logic min;
        logic hour;
        logic day;
        logic mon;
        logic year;
    } tod_adv_t;

    localparam tod_regs_t RESET_REGS = '{
        ctrl: 8'h90, sec: 8'h00, min: 8'h00, hour: 8'h00,
        wday: 8'h01, date: 8'h01, mon: 8'h01, year: 8'h00
    };

    // Both digits decimal and the value inside [lo, hi] (BCD order equals numeric order).
    function automatic logic bcd_in_range(input tod_byte_t v, input tod_byte_t lo,
                                          input tod_byte_t hi);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

    function automatic tod_byte_t bcd_inc(input tod_byte_t v);
        tod_byte_t r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Year mod 4: ten is 2 mod 4, so units + 2*tens decides it.
    function automatic logic bcd_leap(input tod_byte_t yr);
        logic [4:0] s;
        s = {1'b0, yr[3:0]} + {yr[7:4], 1'b0};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic tod_byte_t month_len(input tod_byte_t mon, input tod_byte_t yr);
        tod_byte_t r;
        case (mon)
            8'h02:                      r = bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tod_wr_decode.sv
module tod_wr_decode
    import tod_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  tod_byte_t         wr_data,
    output tod_load_t         ld_o,
    output tod_regs_t         val_o
);

    always_comb begin
        ld_o       = '0;
        val_o.ctrl = (wr_data & 8'h5F) | 8'h90;
        val_o.sec  = {1'b0, wr_data[6:0]};
        val_o.min  = {1'b0, wr_data[6:0]};
        val_o.hour = {2'b0, wr_data[5:0]};
        val_o.wday = {5'b0, wr_data[2:0]};
        val_o.date = {2'b0, wr_data[5:0]};
        val_o.mon  = {3'b0, wr_data[4:0]};
        val_o.year = wr_data;
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(SLOT_CTRL): ld_o.ctrl = 1'b1;
                ADDR_W'(SLOT_SEC): begin
                    ld_o.stop = 1'b1;
                    ld_o.sec  = bcd_in_range(val_o.sec, 8'h00, 8'h59);
                end
                ADDR_W'(SLOT_MIN):  ld_o.min  = bcd_in_range(val_o.min, 8'h00, 8'h59);
                ADDR_W'(SLOT_HOUR): ld_o.hour = bcd_in_range(val_o.hour, 8'h00, 8'h23);
                ADDR_W'(SLOT_WDAY): begin
                    ld_o.wflag = 1'b1;
                    ld_o.wday  = (val_o.wday != 8'h00);
                end
                ADDR_W'(SLOT_DATE): ld_o.date = bcd_in_range(val_o.date, 8'h01, 8'h31);
                ADDR_W'(SLOT_MON):  ld_o.mon  = bcd_in_range(val_o.mon, 8'h01, 8'h12);
                ADDR_W'(SLOT_YEAR): ld_o.year = bcd_in_range(val_o.year, 8'h00, 8'h99);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tod_ripple_fsm.sv
module tod_ripple_fsm
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       stop,
    input  tod_regs_t  regs_i,
    output tod_adv_t   adv_o,
    output tod_regs_t  nx_o,
    output ripple_st_e state_o
);

    ripple_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        adv_o   = '0;
        nx_o    = regs_i;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && !stop) begin
                    adv_o.sec = 1'b1;
                    if (regs_i.sec == 8'h59) begin
                        nx_o.sec = 8'h00;
                        state_d  = ST_MIN;
                    end else begin
                        nx_o.sec = bcd_inc(regs_i.sec);
                    end
                end
            end
            ST_MIN: begin
                adv_o.min = 1'b1;
                if (regs_i.min == 8'h59) begin
                    nx_o.min = 8'h00;
                    state_d  = ST_HOUR;
                end else begin
                    nx_o.min = bcd_inc(regs_i.min);
                    state_d  = ST_IDLE;
                end
            end
            ST_HOUR: begin
                adv_o.hour = 1'b1;
                if (regs_i.hour == 8'h23) begin
                    nx_o.hour = 8'h00;
                    state_d   = ST_DAY;
                end else begin
                    nx_o.hour = bcd_inc(regs_i.hour);
                    state_d   = ST_IDLE;
                end
            end
            ST_DAY: begin
                adv_o.day = 1'b1;
                nx_o.wday = (regs_i.wday >= 8'h07) ? 8'h01 : regs_i.wday + 8'h01;
                if (regs_i.date >= month_len(regs_i.mon, regs_i.year)) begin
                    nx_o.date = 8'h01;
                    state_d   = ST_MONTH;
                end else begin
                    nx_o.date = bcd_inc(regs_i.date);
                    state_d   = ST_IDLE;
                end
            end
            ST_MONTH: begin
                adv_o.mon = 1'b1;
                if (regs_i.mon >= 8'h12) begin
                    nx_o.mon = 8'h01;
                    state_d  = ST_YEAR;
                end else begin
                    nx_o.mon = bcd_inc(regs_i.mon);
                    state_d  = ST_IDLE;
                end
            end
            ST_YEAR: begin
                adv_o.year = 1'b1;
                nx_o.year  = (regs_i.year == 8'h99) ? 8'h00 : bcd_inc(regs_i.year);
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/tod_rd_mux.sv
module tod_rd_mux
    import tod_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  tod_regs_t         regs_i,
    input  logic              stop,
    input  logic              wflag,
    output tod_byte_t         rd_data
);

    always_comb begin
        case (rd_addr)
            ADDR_W'(SLOT_CTRL): rd_data = regs_i.ctrl;
            ADDR_W'(SLOT_SEC):  rd_data = {stop, regs_i.sec[6:0]};
            ADDR_W'(SLOT_MIN):  rd_data = regs_i.min;
            ADDR_W'(SLOT_HOUR): rd_data = regs_i.hour;
            ADDR_W'(SLOT_WDAY): rd_data = {1'b0, wflag, 3'b000, regs_i.wday[2:0]};
            ADDR_W'(SLOT_DATE): rd_data = regs_i.date;
            ADDR_W'(SLOT_MON):  rd_data = regs_i.mon;
            ADDR_W'(SLOT_YEAR): rd_data = regs_i.year;
            default:            rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tod_bcd_regs.sv
module tod_bcd_regs
    import tod_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    tod_regs_t  regs_q;
    logic       stop_q;
    logic       wflag_q;
    tod_load_t  ld;
    tod_regs_t  wval;
    tod_adv_t   adv;
    tod_regs_t  nx;
    ripple_st_e fsm_state;

    tod_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ld_o    (ld),
        .val_o   (wval)
    );

    tod_ripple_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .stop    (stop_q),
        .regs_i  (regs_q),
        .adv_o   (adv),
        .nx_o    (nx),
        .state_o (fsm_state)
    );

    // A write wins over a carry update on the same field.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q  <= RESET_REGS;
            stop_q  <= 1'b0;
            wflag_q <= 1'b0;
        end else begin
            if (ld.ctrl) regs_q.ctrl <= wval.ctrl;
            if (ld.stop) stop_q <= wr_data[7];
            if (ld.wflag) wflag_q <= wr_data[6];

            if (ld.sec)       regs_q.sec <= wval.sec;
            else if (adv.sec) regs_q.sec <= nx.sec;

            if (ld.min)       regs_q.min <= wval.min;
            else if (adv.min) regs_q.min <= nx.min;

            if (ld.hour)       regs_q.hour <= wval.hour;
            else if (adv.hour) regs_q.hour <= nx.hour;

            if (ld.wday)      regs_q.wday <= wval.wday;
            else if (adv.day) regs_q.wday <= nx.wday;

            if (ld.date)      regs_q.date <= wval.date;
            else if (adv.day) regs_q.date <= nx.date;

            if (ld.mon)       regs_q.mon <= wval.mon;
            else if (adv.mon) regs_q.mon <= nx.mon;

            if (ld.year)       regs_q.year <= wval.year;
            else if (adv.year) regs_q.year <= nx.year;
        end
    end

    tod_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
        .rd_addr (rd_addr),
        .regs_i  (regs_q),
        .stop    (stop_q),
        .wflag   (wflag_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/tod_bcd_regs_chk.sv
module tod_bcd_regs_chk
    import tod_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input tod_regs_t         regs,
    input logic              stop,
    input ripple_st_e        st
);

    logic sec_wr;
    assign sec_wr = wr_en && (wr_addr == ADDR_W'(SLOT_SEC));

    p_sec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.sec[3:0] <= 4'd9) && (regs.sec < 8'h60));

    p_hour_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.hour[3:0] <= 4'd9) && (regs.hour < 8'h24));

    p_month_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.mon >= 8'h01) && (regs.mon <= 8'h12) && (regs.mon[3:0] <= 4'd9));

    p_ctrl_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        regs.ctrl[7] && regs.ctrl[4] && !regs.ctrl[5]);

    p_tick_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !sec_wr) |=> $stable(regs.sec));

    p_min_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MIN) |=> (st == ST_HOUR || st == ST_IDLE));

    p_stop_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !sec_wr) |=> $stable(regs.sec));

    p_wday_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.wday >= 8'h01) && (regs.wday <= 8'h07));

endmodule

bind tod_bcd_regs tod_bcd_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .regs    (regs_q),
    .stop    (stop_q),
    .st      (fsm_state)
);

// File: tb/tod_bcd_regs_tb_top.sv
`timescale 1ns/100ps
module tod_bcd_regs_tb_top;

    localparam int ADDR_W = 4;
    localparam int SLOTS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // Reference model, plain integers in binary.
    int m_sec, m_min, m_hr, m_wd, m_date, m_mon, m_yr, m_ctrl, m_stop, m_flag, m_stage;

    always #10 clk = ~clk;

    tod_bcd_regs #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(int v);
        if ((v & 15) > 9 || ((v >> 4) & 15) > 9) return -1;
        return ((v >> 4) & 15) * 10 + (v & 15);
    endfunction

    function automatic int days_in(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int expect_rd(int a);
        case (a)
            0: return m_ctrl;
            1: return (m_stop << 7) | to_bcd(m_sec);
            2: return to_bcd(m_min);
            3: return to_bcd(m_hr);
            4: return (m_flag << 6) | m_wd;
            5: return to_bcd(m_date);
            6: return to_bcd(m_mon);
            7: return to_bcd(m_yr);
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_wd = 1; m_date = 1; m_mon = 1; m_yr = 0;
        m_ctrl = 'h90; m_stop = 0; m_flag = 0; m_stage = 0;
    endtask

    task automatic model_edge(bit we, int wa, int wd, bit tk);
        int n_sec, n_min, n_hr, n_wd, n_date, n_mon, n_yr, n_stage, t;
        n_sec = m_sec; n_min = m_min; n_hr = m_hr; n_wd = m_wd;
        n_date = m_date; n_mon = m_mon; n_yr = m_yr; n_stage = 0;
        case (m_stage)
            0: if (tk && m_stop == 0) begin
                   n_sec = m_sec + 1;
                   if (n_sec == 60) begin n_sec = 0; n_stage = 1; end
               end
            1: begin n_min = m_min + 1; if (n_min == 60) begin n_min = 0; n_stage = 2; end end
            2: begin n_hr = m_hr + 1; if (n_hr == 24) begin n_hr = 0; n_stage = 3; end end
            3: begin
                   n_wd = (m_wd == 7) ? 1 : m_wd + 1;
                   if (m_date >= days_in(m_mon, m_yr)) begin n_date = 1; n_stage = 4; end
                   else n_date = m_date + 1;
               end
            4: begin n_mon = m_mon + 1; if (n_mon == 13) begin n_mon = 1; n_stage = 5; end end
            default: n_yr = (m_yr + 1) % 100;
        endcase
        if (we) begin
            case (wa)
                0: m_ctrl = (wd & 'h5F) | 'h90;
                1: begin
                       t = from_bcd(wd & 'h7F);
                       if (t >= 0 && t <= 59) n_sec = t;
                       m_stop = (wd >> 7) & 1;
                   end
                2: begin t = from_bcd(wd & 'h7F); if (t >= 0 && t <= 59) n_min = t; end
                3: begin t = from_bcd(wd & 'h3F); if (t >= 0 && t <= 23) n_hr = t; end
                4: begin if ((wd & 7) != 0) n_wd = wd & 7; m_flag = (wd >> 6) & 1; end
                5: begin t = from_bcd(wd & 'h3F); if (t >= 1 && t <= 31) n_date = t; end
                6: begin t = from_bcd(wd & 'h1F); if (t >= 1 && t <= 12) n_mon = t; end
                7: begin t = from_bcd(wd); if (t >= 0 && t <= 99) n_yr = t; end
                default: ;
            endcase
        end
        m_sec = n_sec; m_min = n_min; m_hr = n_hr; m_wd = n_wd;
        m_date = n_date; m_mon = n_mon; m_yr = n_yr; m_stage = n_stage;
    endtask

    task automatic chk(int a, int act, int exp, string t);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s slot %0d: actual %02h expected %02h", t, a, act, exp);
        end
    endtask

    // Sweeps every slot against the model during the low phase.
    task automatic compare_all();
        for (int a = 0; a < SLOTS; a++) begin
            rd_addr = ADDR_W'(a);
            #0.5;
            chk(a, int'(rd_data), expect_rd(a), tag);
        end
    endtask

    // Fixed expected value, worked out by hand.
    task automatic expect_slot(int a, int e, string t);
        rd_addr = ADDR_W'(a);
        #0.2;
        chk(a, int'(rd_data), e, t);
    endtask

    task automatic step(bit we, int wa, int wd, bit tk);
        wr_en = we; wr_addr = ADDR_W'(wa); wr_data = 8'(wd); tick = tk;
        @(posedge clk);
        #1;
        model_edge(we, wa, wd, tk);
        wr_en = 1'b0; tick = 1'b0;
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int a, int d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0);
    endtask

    task automatic tk_settle();
        step(1'b0, 0, 0, 1'b1);
        idle(6);
    endtask

    task automatic set_time(int yr, int mon, int date, int wd, int hr, int mi, int se);
        wr(7, yr); wr(6, mon); wr(5, date); wr(4, wd); wr(3, hr); wr(2, mi); wr(1, se);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        compare_all();
        expect_slot(0, 'h90, "R1");
        expect_slot(5, 'h01, "R1");

        tag = "R2";
        wr(1, 'h45); expect_slot(1, 'h45, "R2");
        wr(1, 'h5A); expect_slot(1, 'h45, "R2");
        wr(1, 'h60); expect_slot(1, 'h45, "R2");
        wr(1, 'hC7); expect_slot(1, 'hC7, "R2");
        wr(1, 'h07);

        tag = "R3";
        wr(2, 'h59); wr(2, 'h60); expect_slot(2, 'h59, "R3");
        wr(3, 'h92); expect_slot(3, 'h12, "R3");
        wr(3, 'h24); expect_slot(3, 'h12, "R3");

        tag = "R4";
        wr(5, 'h00); wr(5, 'h31); wr(5, 'h32); expect_slot(5, 'h31, "R4");
        wr(6, 'h13); wr(6, 'h00); wr(6, 'h12); expect_slot(6, 'h12, "R4");
        wr(7, 'h99); wr(7, 'hA0); wr(7, 'h3C); expect_slot(7, 'h99, "R4");

        tag = "R5";
        wr(4, 'h47); expect_slot(4, 'h47, "R5");
        wr(4, 'h48); expect_slot(4, 'h47, "R5");
        wr(4, 'hB5); expect_slot(4, 'h05, "R5");

        tag = "R6";
        wr(0, 'hFF); expect_slot(0, 'hDF, "R6");
        wr(0, 'h00); expect_slot(0, 'h90, "R6");

        tag = "R7";
        set_time('h99, 'h12, 'h31, 'h07, 'h23, 'h59, 'h59);
        step(1'b0, 0, 0, 1'b1);
        step(1'b0, 0, 0, 1'b1);
        idle(6);
        expect_slot(1, 'h00, "R7");
        expect_slot(7, 'h00, "R7");
        expect_slot(6, 'h01, "R9");
        expect_slot(4, 'h01, "R10");

        tag = "R9";
        set_time('h24, 'h02, 'h28, 'h03, 'h23, 'h59, 'h59);
        tk_settle(); expect_slot(5, 'h29, "R9");
        set_time('h24, 'h02, 'h29, 'h03, 'h23, 'h59, 'h59);
        tk_settle(); expect_slot(6, 'h03, "R9");
        set_time('h23, 'h02, 'h28, 'h03, 'h23, 'h59, 'h59);
        tk_settle(); expect_slot(5, 'h01, "R9");
        set_time('h23, 'h04, 'h30, 'h06, 'h23, 'h59, 'h59);
        tk_settle(); expect_slot(6, 'h05, "R9");

        tag = "R10";
        set_time('h23, 'h05, 'h10, 'h07, 'h23, 'h59, 'h59);
        tk_settle(); expect_slot(4, 'h01, "R10");

        tag = "R8";
        wr(1, 'h90);
        tk_settle(); tk_settle(); expect_slot(1, 'h90, "R8");
        wr(1, 'h7F); expect_slot(1, 'h10, "R8");
        tk_settle(); expect_slot(1, 'h11, "R8");

        tag = "R11";
        wr(9, 'h55); expect_slot(9, 'h00, "R11");
        wr(15, 'hFF); expect_slot(15, 'h00, "R11");

        tag = "R12";
        set_time('h23, 'h05, 'h10, 'h02, 'h05, 'h59, 'h59);
        step(1'b0, 0, 0, 1'b1);
        wr(2, 'h30);
        idle(5);
        expect_slot(2, 'h30, "R12");
        expect_slot(3, 'h06, "R12");

        tag = "R7";
        set_time('h99, 'h12, 'h31, 'h07, 'h23, 'h58, 'h30);
        for (int i = 0; i < 200; i++) tk_settle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule